// File: doc/BRIEF.md
# Sum-Addressed Word Line Decoder

This block turns a base operand and an offset operand into a set of one-hot word line selects. The line whose index equals the wrapped sum of the two operands is raised. No adder sits in the path. Instead, every word line has a small comparator that tests whether the two operands add up to that line's own constant index.

For each bit of an operand pair, the comparator first works out which carry into that bit would make the sum bit equal the constant bit. It then checks that the bit pair just below actually produces that carry. This check needs only adjacent bit pairs, so no carry ripples across the word. A line is raised only when every bit position agrees, which is an AND-reduce over the per-bit checks. The constant 2^AW lines share the generate and half-sum terms of the operands.

An optional input register captures the operands and the enable on the rising clock edge. The decode then follows combinationally from the registered values. With the register removed, the whole block is combinational, and the clock and reset pins have no effect. The enable gates every line.

Top module: `sum_wl_decoder`

## Requirements
- R1: When the effective enable is high, wl[i] is 1 exactly when (a + b) mod 2^AW equals i. Here wl[i] is bit i of the word line bus.
- R2: The sum wraps: a carry out of the most significant operand bit is discarded, so a = 2^AW-1 with b = 1 selects line 0, and a = b = 2^AW-1 selects line 2^AW-2.
- R3: When the effective enable is high, exactly one word line is 1.
- R4: When the effective enable is low, every word line is 0.
- R5: With REG_IN = 1, all word lines are 0 while rst_n is low and immediately after its release, until the first rising clock edge that captures a high enable.
- R6: With REG_IN = 1, wl reflects the en, a and b that were sampled at the most recent rising clock edge. Input changes between edges do not alter wl until the next edge. With REG_IN = 0, wl follows the inputs directly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional input register |
| rst_n | input | 1 | Asynchronous active-low reset of the input register |
| en | input | 1 | Decode enable; when low, no line is raised |
| a | input | AW | Base operand |
| b | input | AW | Offset operand |
| wl | output | 2^AW | One-hot word line selects |

## Verification
On every cycle, the bound checker verifies several properties. Exactly one line is high when the enable is high, and no line is high when it is low. The raised line matches the index given by the wrapped sum of the delayed inputs. Word lines also stay at zero during reset.

Only the bench's scenarios can show the one-cycle capture timing. This covers the inputs changing between edges while the lines hold, and the wrap cases at the top of the range. Those scenarios also cover the full sweep of operand pairs on a small instance. In addition, they cover random operands on a wide instance without the input register.

// File: rtl/sum_wl_decoder.sv
module sum_wl_decoder #(
  parameter int AW     = 4,
  parameter bit REG_IN = 1'b1,
  localparam int NL    = 1 << AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [AW-1:0] a,
  input  logic [AW-1:0] b,
  output logic [NL-1:0] wl
);

  logic          en_s;
  logic [AW-1:0] a_s, b_s;

  if (REG_IN) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        en_s <= 1'b0;
        a_s  <= '0;
        b_s  <= '0;
      end else begin
        en_s <= en;
        a_s  <= a;
        b_s  <= b;
      end
    end
  end else begin : g_comb
    assign en_s = en;
    assign a_s  = a;
    assign b_s  = b;
  end

  logic [AW-1:0] hs, gs;
  assign hs = a_s ^ b_s;
  assign gs = a_s & b_s;

  for (genvar k = 0; k < NL; k++) begin : g_line
    localparam logic [AW-1:0] KV = AW'(k);
    logic [AW-1:0] need, gen, ok;
    assign need = hs ^ KV;
    assign gen  = gs | (hs & need);
    assign ok   = ~(need ^ {gen[AW-2:0], 1'b0});
    assign wl[k] = en_s & (&ok);
  end

endmodule

module sum_wl_decoder_chk #(
  parameter int AW     = 4,
  parameter bit REG_IN = 1'b1,
  localparam int NL    = 1 << AW
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic [AW-1:0] a,
  input logic [AW-1:0] b,
  input logic [NL-1:0] wl
);

  logic          p_en, p_vld;
  logic [AW-1:0] p_a, p_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_en  <= 1'b0;
      p_vld <= 1'b0;
      p_a   <= '0;
      p_b   <= '0;
    end else begin
      p_en  <= en;
      p_vld <= 1'b1;
      p_a   <= a;
      p_b   <= b;
    end
  end

  logic          x_en;
  logic [AW-1:0] x_sum;
  assign x_en  = REG_IN ? (p_en & p_vld) : en;
  assign x_sum = REG_IN ? AW'(p_a + p_b) : AW'(a + b);

  AST_SUM_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    x_en |-> wl[x_sum]) else $error("sum line low"); // R1

  AST_ONE_HOT: assert property (@(posedge clk) disable iff (!rst_n)
    x_en |-> ($countones(wl) == 1)) else $error("not one-hot"); // R3

  AST_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !x_en |-> (wl == '0)) else $error("line raised while idle"); // R4

  always @(negedge clk) begin
    if (REG_IN && !rst_n)
      AST_RESET_QUIET: assert (wl == '0) else $error("line raised in reset"); // R5
  end

endmodule

bind sum_wl_decoder sum_wl_decoder_chk #(.AW(AW), .REG_IN(REG_IN)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .a(a), .b(b), .wl(wl)
);

// File: tb/sim_sum_wl_decoder.sv
`timescale 1ns/1ps
module sim_sum_wl_decoder;
  localparam int AW0 = 4;
  localparam int NL0 = 1 << AW0;
  localparam int AW1 = 10;
  localparam int NL1 = 1 << AW1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic           en0 = 1'b0, en1 = 1'b0;
  logic [AW0-1:0] a0 = '0, b0 = '0;
  logic [AW1-1:0] a1 = '0, b1 = '0;
  logic [NL0-1:0] wl0;
  logic [NL1-1:0] wl1;

  int checks = 0;
  int errors = 0;

  sum_wl_decoder #(.AW(AW0), .REG_IN(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .en(en0), .a(a0), .b(b0), .wl(wl0));
  sum_wl_decoder #(.AW(AW1), .REG_IN(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .en(en1), .a(a1), .b(b1), .wl(wl1));

  function automatic logic [NL0-1:0] exp0(input logic e, input logic [AW0-1:0] x, input logic [AW0-1:0] y);
    logic [NL0-1:0] r = '0;
    logic [AW0-1:0] s = x + y;
    if (e) r[s] = 1'b1;
    return r;
  endfunction

  function automatic logic [NL1-1:0] exp1(input logic e, input logic [AW1-1:0] x, input logic [AW1-1:0] y);
    logic [NL1-1:0] r = '0;
    logic [AW1-1:0] s = x + y;
    if (e) r[s] = 1'b1;
    return r;
  endfunction

  task automatic chk0(input string req, input logic [NL0-1:0] expv);
    checks++;
    if (wl0 !== expv) begin
      errors++;
      $display("FAIL %s u0 actual=%h expected=%h", req, wl0, expv);
    end
  endtask

  task automatic step0(input string req, input logic e, input logic [AW0-1:0] x, input logic [AW0-1:0] y);
    @(negedge clk);
    en0 = e; a0 = x; b0 = y;
    @(posedge clk);
    #1;
    chk0(req, exp0(e, x, y));
  endtask

  task automatic step1(input string req, input logic e, input logic [AW1-1:0] x, input logic [AW1-1:0] y);
    en1 = e; a1 = x; b1 = y;
    #2;
    checks++;
    if (wl1 !== exp1(e, x, y)) begin
      errors++;
      $display("FAIL %s u1 a=%0d b=%0d actual_ones=%0d expected_line=%0d", req, x, y,
               $countones(wl1), (e ? int'(AW1'(x + y)) : -1));
    end
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    en0 = 1'b1; a0 = 4'd3; b0 = 4'd4;
    repeat (3) @(posedge clk);
    #1;
    chk0("R5 reset quiet", '0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk0("R5 after release", '0);

    step0("R2 wrap max+1", 1'b1, 4'hF, 4'h1);
    step0("R2 wrap max+max", 1'b1, 4'hF, 4'hF);
    step0("R1 zero+zero", 1'b1, 4'h0, 4'h0);
    step0("R4 disabled", 1'b0, 4'h5, 4'h6);

    for (int x = 0; x < NL0; x++)
      for (int y = 0; y < NL0; y++)
        step0("R1 R3 sweep", 1'b1, AW0'(x), AW0'(y));

    for (int n = 0; n < 40; n++)
      step0("R4 random idle", 1'b0, AW0'($urandom), AW0'($urandom));

    // R6: hold between edges
    step0("R6 setup", 1'b1, 4'd2, 4'd9);
    @(negedge clk);
    a0 = 4'd7; b0 = 4'd7; en0 = 1'b0;
    #1;
    chk0("R6 hold mid-cycle", exp0(1'b1, 4'd2, 4'd9));
    @(posedge clk);
    #1;
    chk0("R6 new capture", '0);

    step1("R2 wide wrap", 1'b1, '1, 10'd1);
    step1("R4 wide idle", 1'b0, 10'd77, 10'd5);
    for (int n = 0; n < 400; n++)
      step1("R1 R3 R6 wide random", 1'(n % 7 != 0), AW1'($urandom), AW1'($urandom));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule